// File: doc/BRIEF.md
# Reference Clock Quality Monitor

This block judges whether one incoming reference clock is good enough to synchronize to. The reference has already been brought into a fast master-clock domain and reduced to a single-cycle pulse per rising edge. The block runs two fast checks on that pulse stream. A per-period check measures the gap between consecutive edges in master-clock cycles. A windowed frequency check counts edges over a programmable window of master-clock cycles.

Failure events from both checks feed a leaky soak integrator. The integrator raises a disqualification flag once enough failures pile up. It drops the flag only after a quiet interval has drained it to a lower threshold. With a fixed decay step this makes the requalification time a fixed multiple of the decay step time.

A reference selector reads the three flags. Software programs the limits to suit the nominal reference rate. For example, it sets the period limits at 50% below and 50% above nominal, sizes the window to about 30 µs, and places the count limits about 3% either side of the expected count.

Top module: `refclk_qual_mon`

## Requirements
- R1: After reset, `period_fail`, `freq_fail` and `soak_fail` are low. Neither check judges anything until the first reference edge arms it, and that arming edge raises no flag.
- R2: On every edge after arming, the gap since the previous edge is counted in master-clock cycles and compared with `cfg_per_lo` and `cfg_per_hi`, both bounds inclusive. `period_fail` shows the verdict from the cycle after the edge.
- R3: A missing edge sets `period_fail` without waiting for the next edge. When `cfg_per_hi`+1 master-clock cycles pass with no edge, the flag rises in that cycle. Each gap produces only one failure event.
- R4: The frequency window lasts `cfg_win_m1`+1 cycles and starts with the arming edge. Windows follow back to back. At the end of each window, `freq_fail` is set if the edge count lies outside [`cfg_cnt_lo`, `cfg_cnt_hi`] and cleared otherwise. Between window ends the flag holds its value.
- R5: Each failure detection from an unmasked check adds one to the soak accumulator.
- R6: `soak_fail` rises in the cycle the accumulator reaches `cfg_soak_hi`.
- R7: After `cfg_decay_m1`+1 consecutive cycles with no unmasked event, the accumulator drops by one. `soak_fail` clears only when the accumulator reaches `cfg_soak_lo`, so requalification takes (`cfg_soak_hi` − `cfg_soak_lo`) × (`cfg_decay_m1`+1) quiet cycles.
- R8: The accumulator saturates at `cfg_soak_hi` and stops decaying at zero. Because of this, the time to clear after a long failure burst does not depend on the length of the burst.
- R9: With `ign_period` high, period failures do not feed the soak accumulator, and `ign_freq` does the same for window failures. A masked check still drives its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_edge | input | 1 | One-cycle pulse per synchronized reference rising edge |
| cfg_per_lo | input | PER_W | Shortest acceptable period, in cycles |
| cfg_per_hi | input | PER_W | Longest acceptable period, in cycles |
| cfg_win_m1 | input | WIN_W | Frequency window length minus one |
| cfg_cnt_lo | input | ECNT_W | Fewest acceptable edges per window |
| cfg_cnt_hi | input | ECNT_W | Most acceptable edges per window |
| ign_period | input | 1 | Keep period failures out of the soak accumulator |
| ign_freq | input | 1 | Keep window failures out of the soak accumulator |
| cfg_soak_hi | input | ACC_W | Accumulator level that disqualifies |
| cfg_soak_lo | input | ACC_W | Accumulator level that requalifies |
| cfg_decay_m1 | input | DEC_W | Quiet cycles per decay step, minus one |
| period_fail | output | 1 | Period check verdict |
| freq_fail | output | 1 | Window check verdict |
| soak_fail | output | 1 | Disqualification flag from the soak integrator |

## Verification
The assertions rely on several properties of the inputs:
- The configuration inputs and both masks hold still while reset is released.
- `cfg_soak_lo` is below `cfg_soak_hi`.
- `cfg_per_hi` is below the largest value of the period counter.
- `cfg_win_m1` is at least one.
- `ref_edge` is never high for two cycles in a row.

The stimulus sets every configuration value at time zero. It changes masks only while reset is asserted, and each scenario begins with a fresh reset. Reference edges are generated as single-cycle pulses separated by an explicit gap.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam int unsigned PER_W_DEF  = 16;
  localparam int unsigned WIN_W_DEF  = 16;
  localparam int unsigned ECNT_W_DEF = 8;
  localparam int unsigned ACC_W_DEF  = 8;
  localparam int unsigned DEC_W_DEF  = 16;

  typedef struct packed {
    logic period;
    logic freq;
  } rcm_evt_t;
endpackage

// File: rtl/rcm_rst_sync.sv
module rcm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rcm_period_chk.sv
module rcm_period_chk #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic [PER_W-1:0] cfg_per_lo,
  input  logic [PER_W-1:0] cfg_per_hi,
  output logic             period_fail,
  output logic             period_evt
);
  localparam logic [PER_W-1:0] CNT_MAX = '1;

  logic             armed_q, armed_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             gap_q, gap_d;
  logic             fail_q, fail_d;
  logic             out_of_range;
  logic             gap_hit;

  always_comb begin
    armed_d      = armed_q;
    cnt_d        = cnt_q;
    gap_d        = gap_q;
    fail_d       = fail_q;
    period_evt   = 1'b0;
    out_of_range = (cnt_q < cfg_per_lo) || (cnt_q > cfg_per_hi);
    gap_hit      = armed_q && !ref_edge && (cnt_q > cfg_per_hi) && !gap_q;
    if (ref_edge) begin
      armed_d = 1'b1;
      cnt_d   = {{(PER_W-1){1'b0}}, 1'b1};
      gap_d   = 1'b0;
      if (armed_q) begin
        fail_d     = out_of_range;
        period_evt = out_of_range && !gap_q;
      end
    end else begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (gap_hit) begin
        fail_d     = 1'b1;
        gap_d      = 1'b1;
        period_evt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      gap_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
      fail_q  <= fail_d;
    end
  end

  assign period_fail = fail_q;

  p_unarmed_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !period_fail);
  p_in_range_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ref_edge && cnt_q >= cfg_per_lo && cnt_q <= cfg_per_hi) |=> !period_fail);
  p_missing_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !ref_edge && cnt_q > cfg_per_hi) |=> period_fail);
endmodule

// File: rtl/rcm_window_chk.sv
module rcm_window_chk #(
  parameter int unsigned WIN_W  = 16,
  parameter int unsigned ECNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_edge,
  input  logic [WIN_W-1:0]  cfg_win_m1,
  input  logic [ECNT_W-1:0] cfg_cnt_lo,
  input  logic [ECNT_W-1:0] cfg_cnt_hi,
  output logic              freq_fail,
  output logic              freq_evt
);
  localparam logic [ECNT_W-1:0] ECNT_MAX = '1;

  logic              armed_q, armed_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [ECNT_W-1:0] ecnt_q, ecnt_d;
  logic              fail_q, fail_d;
  logic              active;
  logic              win_end;
  logic [ECNT_W-1:0] ecnt_inc;
  logic              count_bad;

  always_comb begin
    armed_d   = armed_q;
    win_d     = win_q;
    ecnt_d    = ecnt_q;
    fail_d    = fail_q;
    freq_evt  = 1'b0;
    active    = armed_q || ref_edge;
    win_end   = active && (win_q == cfg_win_m1);
    ecnt_inc  = (ref_edge && ecnt_q != ECNT_MAX) ? ecnt_q + 1'b1 : ecnt_q;
    count_bad = (ecnt_inc < cfg_cnt_lo) || (ecnt_inc > cfg_cnt_hi);
    if (active) begin
      armed_d = 1'b1;
      if (win_end) begin
        win_d    = '0;
        ecnt_d   = '0;
        fail_d   = count_bad;
        freq_evt = count_bad;
      end else begin
        win_d  = win_q + 1'b1;
        ecnt_d = ecnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      win_q   <= '0;
      ecnt_q  <= '0;
      fail_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      win_q   <= win_d;
      ecnt_q  <= ecnt_d;
      fail_q  <= fail_d;
    end
  end

  assign freq_fail = fail_q;

  p_unarmed_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !freq_fail);
  p_hold_mid_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(freq_fail));
endmodule

// File: rtl/rcm_soak.sv
module rcm_soak
  import rcm_pkg::*;
#(
  parameter int unsigned ACC_W = 8,
  parameter int unsigned DEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rcm_evt_t         evt,
  input  logic             ign_period,
  input  logic             ign_freq,
  input  logic [ACC_W-1:0] cfg_soak_hi,
  input  logic [ACC_W-1:0] cfg_soak_lo,
  input  logic [DEC_W-1:0] cfg_decay_m1,
  output logic             soak_fail
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [DEC_W-1:0] tmr_q, tmr_d;
  logic             fail_q, fail_d;
  logic             hit_p, hit_f, any_hit;
  logic [1:0]       inc;
  logic [ACC_W:0]   sum;

  always_comb begin
    hit_p   = evt.period && !ign_period;
    hit_f   = evt.freq && !ign_freq;
    any_hit = hit_p || hit_f;
    inc     = {1'b0, hit_p} + {1'b0, hit_f};
    sum     = {1'b0, acc_q} + {{(ACC_W-1){1'b0}}, inc};
    acc_d   = acc_q;
    tmr_d   = tmr_q;
    if (any_hit) begin
      tmr_d = '0;
      acc_d = (sum >= {1'b0, cfg_soak_hi}) ? cfg_soak_hi : sum[ACC_W-1:0];
    end else if (tmr_q == cfg_decay_m1) begin
      tmr_d = '0;
      if (acc_q != '0) acc_d = acc_q - 1'b1;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
    fail_d = fail_q;
    if (acc_d >= cfg_soak_hi)      fail_d = 1'b1;
    else if (acc_d <= cfg_soak_lo) fail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tmr_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tmr_q  <= tmr_d;
      fail_q <= fail_d;
    end
  end

  assign soak_fail = fail_q;

  p_set_at_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q >= cfg_soak_hi) |-> soak_fail);
  p_clear_at_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= cfg_soak_lo) |-> !soak_fail);
  p_acc_capped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= cfg_soak_hi);
  p_masked_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_period && ign_freq) |=> (acc_q <= $past(acc_q)));
endmodule

// File: rtl/refclk_qual_mon.sv
module refclk_qual_mon
  import rcm_pkg::*;
#(
  parameter int unsigned PER_W  = PER_W_DEF,
  parameter int unsigned WIN_W  = WIN_W_DEF,
  parameter int unsigned ECNT_W = ECNT_W_DEF,
  parameter int unsigned ACC_W  = ACC_W_DEF,
  parameter int unsigned DEC_W  = DEC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_edge,
  input  logic [PER_W-1:0]  cfg_per_lo,
  input  logic [PER_W-1:0]  cfg_per_hi,
  input  logic [WIN_W-1:0]  cfg_win_m1,
  input  logic [ECNT_W-1:0] cfg_cnt_lo,
  input  logic [ECNT_W-1:0] cfg_cnt_hi,
  input  logic              ign_period,
  input  logic              ign_freq,
  input  logic [ACC_W-1:0]  cfg_soak_hi,
  input  logic [ACC_W-1:0]  cfg_soak_lo,
  input  logic [DEC_W-1:0]  cfg_decay_m1,
  output logic              period_fail,
  output logic              freq_fail,
  output logic              soak_fail
);
  logic     rst_core_n;
  rcm_evt_t evt;

  rcm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  rcm_period_chk #(.PER_W(PER_W)) u_period (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ref_edge    (ref_edge),
    .cfg_per_lo  (cfg_per_lo),
    .cfg_per_hi  (cfg_per_hi),
    .period_fail (period_fail),
    .period_evt  (evt.period)
  );

  rcm_window_chk #(.WIN_W(WIN_W), .ECNT_W(ECNT_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ref_edge   (ref_edge),
    .cfg_win_m1 (cfg_win_m1),
    .cfg_cnt_lo (cfg_cnt_lo),
    .cfg_cnt_hi (cfg_cnt_hi),
    .freq_fail  (freq_fail),
    .freq_evt   (evt.freq)
  );

  rcm_soak #(.ACC_W(ACC_W), .DEC_W(DEC_W)) u_soak (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .evt          (evt),
    .ign_period   (ign_period),
    .ign_freq     (ign_freq),
    .cfg_soak_hi  (cfg_soak_hi),
    .cfg_soak_lo  (cfg_soak_lo),
    .cfg_decay_m1 (cfg_decay_m1),
    .soak_fail    (soak_fail)
  );
endmodule

// File: tb/refclk_qual_mon_tb.sv
module refclk_qual_mon_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_edge;
  logic [15:0] cfg_per_lo, cfg_per_hi, cfg_win_m1, cfg_decay_m1;
  logic [7:0]  cfg_cnt_lo, cfg_cnt_hi, cfg_soak_hi, cfg_soak_lo;
  logic        ign_period, ign_freq;
  logic        period_fail, freq_fail, soak_fail;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  refclk_qual_mon u_dut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge),
    .cfg_per_lo(cfg_per_lo), .cfg_per_hi(cfg_per_hi),
    .cfg_win_m1(cfg_win_m1), .cfg_cnt_lo(cfg_cnt_lo), .cfg_cnt_hi(cfg_cnt_hi),
    .ign_period(ign_period), .ign_freq(ign_freq),
    .cfg_soak_hi(cfg_soak_hi), .cfg_soak_lo(cfg_soak_lo), .cfg_decay_m1(cfg_decay_m1),
    .period_fail(period_fail), .freq_fail(freq_fail), .soak_fail(soak_fail)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic ip, input logic ifr);
    ref_edge   = 1'b0;
    rst_n      = 1'b0;
    ign_period = ip;
    ign_freq   = ifr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic edge_after(input int gap);
    repeat (gap - 1) @(negedge clk);
    ref_edge = 1'b1;
    @(negedge clk);
    ref_edge = 1'b0;
  endtask

  task automatic edges(input int n, input int gap);
    for (int i = 0; i < n; i++) edge_after(gap);
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b0);
    check_bit("R1 period_fail after reset", period_fail, 1'b0);
    check_bit("R1 freq_fail after reset", freq_fail, 1'b0);
    check_bit("R1 soak_fail after reset", soak_fail, 1'b0);
    repeat (150) @(negedge clk);
    check_bit("R1 no window verdict before arming", freq_fail, 1'b0);
    check_bit("R1 no period verdict before arming", period_fail, 1'b0);
    edge_after(5);
    check_bit("R1 arming edge raises nothing", period_fail, 1'b0);
  endtask

  task automatic t_period;
    do_reset(1'b0, 1'b0);
    edges(4, 10);
    check_bit("R2 nominal period", period_fail, 1'b0);
    edge_after(12);
    check_bit("R2 period at upper bound", period_fail, 1'b0);
    edge_after(13);
    check_bit("R2 period above upper bound", period_fail, 1'b1);
    edge_after(10);
    check_bit("R2 recovers on good period", period_fail, 1'b0);
    edge_after(8);
    check_bit("R2 period at lower bound", period_fail, 1'b0);
    edge_after(7);
    check_bit("R2 period below lower bound", period_fail, 1'b1);
    edge_after(10);
    check_bit("R2 recovers again", period_fail, 1'b0);
  endtask

  task automatic t_missing;
    do_reset(1'b0, 1'b0);
    edges(3, 10);
    repeat (12) @(negedge clk);
    check_bit("R3 no flag at high limit", period_fail, 1'b0);
    @(negedge clk);
    check_bit("R3 flag one cycle past high limit", period_fail, 1'b1);
  endtask

  task automatic t_freq;
    do_reset(1'b0, 1'b0);
    edges(30, 10);
    check_bit("R4 nominal count passes", freq_fail, 1'b0);
    do_reset(1'b0, 1'b0);
    edges(25, 11);
    check_bit("R4 count at lower limit passes", freq_fail, 1'b0);
    do_reset(1'b0, 1'b0);
    edges(25, 12);
    check_bit("R4 slow reference fails window", freq_fail, 1'b1);
    check_bit("R4 slow reference still passes period", period_fail, 1'b0);
    do_reset(1'b0, 1'b0);
    edges(14, 8);
    check_bit("R4 fast reference fails window", freq_fail, 1'b1);
  endtask

  task automatic t_soak;
    do_reset(1'b0, 1'b1);
    edge_after(10);
    edges(3, 20);
    check_bit("R6 below top after three events", soak_fail, 1'b0);
    edge_after(20);
    check_bit("R5 R6 set at fourth event", soak_fail, 1'b1);
    edges(6, 20);
    edges(8, 10);
    repeat (8) @(negedge clk);
    check_bit("R7 held during decay", soak_fail, 1'b1);
    @(negedge clk);
    check_bit("R8 clears three steps after burst", soak_fail, 1'b0);
  endtask

  task automatic t_mask;
    do_reset(1'b1, 1'b1);
    edge_after(10);
    edges(8, 20);
    check_bit("R9 masked check keeps own flag", period_fail, 1'b1);
    check_bit("R9 both masked no soak", soak_fail, 1'b0);
    do_reset(1'b1, 1'b0);
    edge_after(10);
    edges(8, 20);
    check_bit("R9 window failed", freq_fail, 1'b1);
    check_bit("R9 period masked soak stays low", soak_fail, 1'b0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    ref_edge     = 1'b0;
    ign_period   = 1'b0;
    ign_freq     = 1'b0;
    cfg_per_lo   = 16'd8;
    cfg_per_hi   = 16'd12;
    cfg_win_m1   = 16'd99;
    cfg_cnt_lo   = 8'd9;
    cfg_cnt_hi   = 8'd11;
    cfg_soak_hi  = 8'd4;
    cfg_soak_lo  = 8'd1;
    cfg_decay_m1 = 16'd31;
    t_reset();
    t_period();
    t_missing();
    t_freq();
    t_soak();
    t_mask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule